// File: doc/BRIEF.md
# Downstream Connection and Stuck-Low Timeout Controller

This block decides when an upstream two-wire bus is actually joined to each of two downstream buses, and it guards the joined buses against being held low. Software writes a pair of switch-request bits; when the write lands, the block compares each request with a sampled logic-high flag from that downstream bus. Unless the override bit is set, a channel whose bus reads low is not joined. A request for a low channel also records a failed attempt and raises an alert request. A channel that is already joined stays joined, whatever its flag says.

A stuck-low timer watches two digital flags from the common node of the downstream switches. One flag says that a node is below the low threshold and the other says that both nodes are above the high threshold. The 2-bit mode selects a limit of 30, 15 or 7.5 ms, or turns the timer off. The time base is a half-millisecond prescaler set by a parameter. When the timer expires, the buffers are cut and READY is pulled low, but the switch bits are left as they were. A real-time bit follows the expired condition. A latched bit and a timeout alert request hold until a fault-clear pulse, and while the latched bit is set no second timeout can start.

Top module: `dsconn_ctrl`

## Requirements
- R1: With `force_conn`=0, a `req_wr` pulse sets `sw_en[i]` only where `req_sw[i]`=1 and `bus_high[i]`=1, or where `sw_en[i]` was already 1. The new value shows one cycle after the pulse.
- R2: With `force_conn`=0, a `req_wr` pulse that requests a channel whose `bus_high` is 0 and which is not already joined sets `fail_n` to 0 and `alert_conn` to 1 on the next edge. A `fault_clr` pulse returns `fail_n` to 1 and `alert_conn` to 0.
- R3: With `force_conn`=1, a `req_wr` pulse copies `req_sw` into `sw_en` whatever `bus_high` is, and it leaves `fail_n` unchanged.
- R4: A channel with `sw_en[i]`=1 that is requested again stays joined even when its `bus_high[i]` is 0. The same write may still flag a failed attempt for a low channel that is newly requested.
- R5: The timer advances only while `node_low`=1. It clears on any cycle with `node_high`=1, and it holds its count when both flags are 0.
- R6: `tmo_mode` 0 disables the timer, and 1, 2 and 3 select 60, 30 and 15 half-millisecond units, each unit being `HALF_MS_TICKS` cycles. From a cleared timer with `node_low` held, `tmo_live` rises on the N-th clock edge, where N = units × `HALF_MS_TICKS`.
- R7: While `tmo_live`=1, `buf_active`, `ready` and `any_conn` are 0, and `sw_en` keeps its value.
- R8: `tmo_live` stays 1 until `node_high` or mode 0 is seen. `tmo_latched` and `alert_tmo` rise together with `tmo_live` and fall only on `fault_clr`.
- R9: `buf_active`, `ready` and `any_conn` are 1 exactly when at least one `sw_en` bit is 1 and `tmo_live`=0.
- R10: While `tmo_latched`=1, a new stuck-low period does not advance the timer and cannot raise `tmo_live` again.
- R11: After reset, `sw_en`=0, all three connection outputs are 0, `fail_n`=1, and every timeout and alert output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | One-cycle pulse: a new switch request is applied |
| req_sw | input | 2 | Requested switch state per channel |
| force_conn | input | 1 | 1 = join channels regardless of their logic state |
| bus_high | input | 2 | Sampled flag per channel, 1 = both lines high |
| node_low | input | 1 | A common node is below the low threshold |
| node_high | input | 1 | Both common nodes are above the high threshold |
| tmo_mode | input | 2 | Timeout select: 0 off, 1 = 30 ms, 2 = 15 ms, 3 = 7.5 ms |
| fault_clr | input | 1 | One-cycle pulse that clears the latched faults |
| sw_en | output | 2 | Switch state per channel |
| buf_active | output | 1 | Upstream/downstream buffers are on |
| ready | output | 1 | 1 = released (connected), 0 = pulled low |
| any_conn | output | 1 | Status: a downstream channel is connected |
| fail_n | output | 1 | Failed-attempt status, 0 = attempt failed |
| alert_conn | output | 1 | Alert request for a failed connection |
| tmo_live | output | 1 | Real-time timeout status |
| tmo_latched | output | 1 | Latched timeout status |
| alert_tmo | output | 1 | Alert request for a timeout |

## Verification
The assertions assume that `node_low` and `node_high` never both read 1 in the same cycle, as the two thresholds make that impossible. They also assume that `req_wr` and `fault_clr` are single-cycle pulses. The stimulus keeps to this by lowering one flag before it raises the other and by driving every pulse for one cycle only. The bench uses a short prescaler so that every mode's exact expiry edge can be checked both one cycle early and on the edge itself.

// File: rtl/dsconn_pkg.sv
package dsconn_pkg;
  localparam int NCH           = 2;
  localparam int UNITS_LONG    = 60;
  localparam int UNITS_MID     = 30;
  localparam int UNITS_SHORT   = 15;
  localparam int UNIT_W        = $clog2(UNITS_LONG + 1);

  typedef enum logic [1:0] {
    TMO_OFF   = 2'd0,
    TMO_LONG  = 2'd1,
    TMO_MID   = 2'd2,
    TMO_SHORT = 2'd3
  } tmo_mode_e;

  // half-millisecond units for a timeout mode, 0 = timer disabled
  function automatic logic [UNIT_W-1:0] tmo_units(input logic [1:0] mode);
    logic [UNIT_W-1:0] u;
    case (tmo_mode_e'(mode))
      TMO_LONG:  u = UNIT_W'(UNITS_LONG);
      TMO_MID:   u = UNIT_W'(UNITS_MID);
      TMO_SHORT: u = UNIT_W'(UNITS_SHORT);
      default:   u = '0;
    endcase
    return u;
  endfunction

  // true when a channel may be joined on a request
  function automatic logic chan_ok(input logic frc, input logic high, input logic already);
    return frc | high | already;
  endfunction
endpackage

// File: rtl/dsconn_gate.sv
module dsconn_gate
  import dsconn_pkg::*;
#(
  parameter int CH = NCH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_wr,
  input  logic [CH-1:0] req_sw,
  input  logic          force_conn,
  input  logic [CH-1:0] bus_high,
  output logic [CH-1:0] sw_en,
  output logic          fail_evt
);
  logic [CH-1:0] sw_next;
  logic [CH-1:0] low_hit;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    always_comb begin
      sw_next[i] = req_sw[i] & chan_ok(force_conn, bus_high[i], sw_en[i]);
      low_hit[i] = req_sw[i] & ~chan_ok(force_conn, bus_high[i], sw_en[i]);
    end
  end

  assign fail_evt = req_wr & (|low_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sw_en <= '0;
    else if (req_wr) sw_en <= sw_next;
  end

  // R1
  no_low_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !force_conn) |=> ((sw_en & ~$past(bus_high) & ~$past(sw_en)) == '0));

  // R3
  force_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && force_conn) |=> (sw_en == $past(req_sw)));

  // R7
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_wr |=> $stable(sw_en));
endmodule

// File: rtl/dsconn_timer.sv
module dsconn_timer
  import dsconn_pkg::*;
#(
  parameter int HALF_MS_TICKS = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tmo_mode,
  input  logic       node_low,
  input  logic       node_high,
  input  logic       hold,
  output logic       expired,
  output logic       expire_evt
);
  localparam int PW = (HALF_MS_TICKS > 1) ? $clog2(HALF_MS_TICKS) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(HALF_MS_TICKS - 1);

  logic [PW-1:0]     pcnt;
  logic [UNIT_W-1:0] ucnt;
  logic [UNIT_W-1:0] limit;
  logic              armed;
  logic              running;
  logic              unit_done;
  logic              last_unit;

  always_comb begin
    limit     = tmo_units(tmo_mode);
    armed     = (limit != '0);
    running   = armed && node_low && !node_high && !expired && !hold;
    unit_done = (pcnt == P_LAST);
    last_unit = ({1'b0, ucnt} + 1'b1) >= {1'b0, limit};
  end

  assign expire_evt = running && unit_done && last_unit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt    <= '0;
      ucnt    <= '0;
      expired <= 1'b0;
    end else if (node_high || !armed) begin
      pcnt    <= '0;
      ucnt    <= '0;
      expired <= 1'b0;
    end else if (running) begin
      if (unit_done) begin
        pcnt <= '0;
        if (last_unit) expired <= 1'b1;
        else           ucnt    <= ucnt + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  // R5
  node_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    node_high |=> !expired);

  // R6
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_mode == 2'd0) |=> !expired);

  // R10
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !expired) |=> !expired);
endmodule

// File: rtl/dsconn_faults.sv
module dsconn_faults (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_evt,
  input  logic expire_evt,
  input  logic fault_clr,
  output logic fail_n,
  output logic alert_conn,
  output logic tmo_latched,
  output logic alert_tmo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_n     <= 1'b1;
      alert_conn <= 1'b0;
    end else if (fail_evt) begin
      fail_n     <= 1'b0;
      alert_conn <= 1'b1;
    end else if (fault_clr) begin
      fail_n     <= 1'b1;
      alert_conn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_latched <= 1'b0;
      alert_tmo   <= 1'b0;
    end else if (expire_evt) begin
      tmo_latched <= 1'b1;
      alert_tmo   <= 1'b1;
    end else if (fault_clr) begin
      tmo_latched <= 1'b0;
      alert_tmo   <= 1'b0;
    end
  end

  // R2
  conn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !fail_evt) |=> (fail_n && !alert_conn));

  // R8
  tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !expire_evt) |=> (!tmo_latched && !alert_tmo));
endmodule

// File: rtl/dsconn_ctrl.sv
module dsconn_ctrl
  import dsconn_pkg::*;
#(
  parameter int HALF_MS_TICKS = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_wr,
  input  logic [1:0] req_sw,
  input  logic       force_conn,
  input  logic [1:0] bus_high,
  input  logic       node_low,
  input  logic       node_high,
  input  logic [1:0] tmo_mode,
  input  logic       fault_clr,
  output logic [1:0] sw_en,
  output logic       buf_active,
  output logic       ready,
  output logic       any_conn,
  output logic       fail_n,
  output logic       alert_conn,
  output logic       tmo_live,
  output logic       tmo_latched,
  output logic       alert_tmo
);
  logic fail_evt;
  logic expire_evt;

  dsconn_gate #(.CH(NCH)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_wr     (req_wr),
    .req_sw     (req_sw),
    .force_conn (force_conn),
    .bus_high   (bus_high),
    .sw_en      (sw_en),
    .fail_evt   (fail_evt)
  );

  dsconn_timer #(.HALF_MS_TICKS(HALF_MS_TICKS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmo_mode   (tmo_mode),
    .node_low   (node_low),
    .node_high  (node_high),
    .hold       (tmo_latched),
    .expired    (tmo_live),
    .expire_evt (expire_evt)
  );

  dsconn_faults u_faults (
    .clk         (clk),
    .rst_n       (rst_n),
    .fail_evt    (fail_evt),
    .expire_evt  (expire_evt),
    .fault_clr   (fault_clr),
    .fail_n      (fail_n),
    .alert_conn  (alert_conn),
    .tmo_latched (tmo_latched),
    .alert_tmo   (alert_tmo)
  );

  assign buf_active = (|sw_en) && !tmo_live;
  assign ready      = buf_active;
  assign any_conn   = buf_active;

  // R8
  latch_with_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_live) |-> (tmo_latched && alert_tmo));

  // R3
  force_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && force_conn && !fault_clr) |=> $stable(fail_n));

  // R7
  cut_keeps_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tmo_live) && !$past(req_wr)) |-> $stable(sw_en));
endmodule

// File: tb/dsconn_ctrl_tb.sv
module dsconn_ctrl_tb;
  localparam int TICKS = 2;
  localparam int NVEC  = 8;
  // {req_sw[1:0], force, bus_high[1:0], exp_sw[1:0], exp_fail_n}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b11_0_11_11_1,
    8'b11_0_01_01_0,
    8'b11_0_10_10_0,
    8'b01_0_10_00_0,
    8'b10_1_00_10_1,
    8'b11_1_00_11_1,
    8'b00_0_00_00_1,
    8'b10_0_11_10_1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_wr = 1'b0;
  logic [1:0] req_sw = 2'b00;
  logic force_conn = 1'b0;
  logic [1:0] bus_high = 2'b11;
  logic node_low = 1'b0;
  logic node_high = 1'b1;
  logic [1:0] tmo_mode = 2'd0;
  logic fault_clr = 1'b0;
  logic [1:0] sw_en;
  logic buf_active, ready, any_conn, fail_n, alert_conn;
  logic tmo_live, tmo_latched, alert_tmo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dsconn_ctrl #(.HALF_MS_TICKS(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_sw(req_sw),
    .force_conn(force_conn), .bus_high(bus_high), .node_low(node_low),
    .node_high(node_high), .tmo_mode(tmo_mode), .fault_clr(fault_clr),
    .sw_en(sw_en), .buf_active(buf_active), .ready(ready), .any_conn(any_conn),
    .fail_n(fail_n), .alert_conn(alert_conn), .tmo_live(tmo_live),
    .tmo_latched(tmo_latched), .alert_tmo(alert_tmo)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [1:0] s, input logic f, input logic [1:0] h);
    req_sw = s; force_conn = f; bus_high = h; req_wr = 1'b1;
    step(1);
    req_wr = 1'b0;
  endtask

  task automatic clr();
    fault_clr = 1'b1;
    step(1);
    fault_clr = 1'b0;
  endtask

  task automatic stuck();
    node_high = 1'b0; node_low = 1'b1;
  endtask

  task automatic release_node();
    node_low = 1'b0; node_high = 1'b1;
  endtask

  task automatic expiry(input string tag, input logic [1:0] mode, input int cycles);
    release_node(); tmo_mode = mode; step(1); clr();
    stuck();
    step(cycles - 1);
    chk({tag, " one cycle early"}, {7'd0, tmo_live}, 8'd0);
    step(1);
    chk({tag, " on edge"}, {7'd0, tmo_live}, 8'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11
    chk("R11 reset sw_en", {6'd0, sw_en}, 8'd0);
    chk("R11 reset conn", {5'd0, buf_active, ready, any_conn}, 8'd0);
    chk("R11 reset faults", {3'd0, fail_n, alert_conn, tmo_live, tmo_latched, alert_tmo}, 8'b0001_0000);

    // R1 R2 R3 vector walk
    for (int v = 0; v < NVEC; v++) begin
      cmd(2'b00, 1'b1, 2'b11);
      clr();
      cmd(VEC[v][7:6], VEC[v][5], VEC[v][4:3]);
      chk($sformatf("R1 R3 vec%0d sw_en", v), {6'd0, sw_en}, {6'd0, VEC[v][2:1]});
      chk($sformatf("R2 vec%0d fail", v), {6'd0, fail_n, alert_conn}, {6'd0, VEC[v][0], ~VEC[v][0]});
      chk($sformatf("R9 vec%0d ready", v), {6'd0, ready, any_conn}, {6'd0, {2{|VEC[v][2:1]}}});
    end

    // R2 clear
    clr();
    chk("R2 clear", {6'd0, fail_n, alert_conn}, 8'b10);

    // R4 already joined channel kept
    cmd(2'b00, 1'b1, 2'b11);
    cmd(2'b01, 1'b0, 2'b11);
    cmd(2'b11, 1'b0, 2'b00);
    chk("R4 kept sw_en", {6'd0, sw_en}, 8'b01);
    chk("R4 fail for low ch", {7'd0, fail_n}, 8'd0);
    clr();
    bus_high = 2'b11;

    // R6 R7 R8 mode 3 expiry with channel 0 joined
    expiry("R6 mode3", 2'd3, 15 * TICKS);
    chk("R7 cut buffers", {5'd0, buf_active, ready, any_conn}, 8'd0);
    chk("R7 switch kept", {6'd0, sw_en}, 8'b01);
    chk("R8 latched", {6'd0, tmo_latched, alert_tmo}, 8'b11);

    // R5 hold band keeps expiry, release clears live only
    node_low = 1'b0;
    step(5);
    chk("R5 hold band", {7'd0, tmo_live}, 8'd1);
    node_high = 1'b1;
    step(1);
    chk("R8 live drops", {7'd0, tmo_live}, 8'd0);
    chk("R9 buffers back", {5'd0, buf_active, ready, any_conn}, 8'b111);
    chk("R8 latch holds", {6'd0, tmo_latched, alert_tmo}, 8'b11);

    // R10 no second timeout while latched
    stuck();
    step(40);
    chk("R10 no rearm", {7'd0, tmo_live}, 8'd0);
    release_node();
    clr();
    chk("R8 cleared", {6'd0, tmo_latched, alert_tmo}, 8'd0);

    // R5 release mid-count restarts the timer
    stuck();
    step(20);
    release_node();
    step(1);
    stuck();
    step(15 * TICKS - 1);
    chk("R5 restart early", {7'd0, tmo_live}, 8'd0);
    step(1);
    chk("R5 restart edge", {7'd0, tmo_live}, 8'd1);

    // R6 mode 0 disables
    release_node(); step(1); clr();
    tmo_mode = 2'd0;
    stuck();
    step(200);
    chk("R6 mode0 off", {6'd0, tmo_live, tmo_latched}, 8'd0);

    expiry("R6 mode1", 2'd1, 60 * TICKS);
    expiry("R6 mode2", 2'd2, 30 * TICKS);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule